// File: doc/BRIEF.md
# Quasi-Resonant Valley Index Selector

This block decides in which drain-voltage valley a quasi-resonant flyback controller turns its switch on. It takes a digitised current set-point, given as a percentage of full scale, and two comparator flags from the line-sense input. From these it produces the valley number that the downstream valley counter waits for. Deeper dimming and higher line voltage both push the choice toward later valleys, which keeps the switching frequency within bounds.

Two kinds of hysteresis keep the choice from chattering. The line range is held in a flag that has separate set and clear conditions, and either one must hold without a break for a programmable number of clocks before the flag changes. The set-point is sorted into six bands. Each band edge has one level for a falling set-point and a higher level for a rising set-point, so a set-point that sits between the two levels keeps its current valley. A new valley is applied only on a strobe that marks the end of a switching cycle. A parameter selects one of two tables for high line.

Top module: `valley_select`

## Requirements
- R1: After reset the selected valley is 1, the line-range flag `highLine` is 0 (low line), and the set-point band is the full-scale band.
- R2: At low line the bands from highest to lowest set-point map to valleys 1, 2, 4, 7, 11 and 13.
- R3: At high line the same bands map to valleys 2, 3, 5, 8, 12 and 15 when `VARIANT_B` is 0, and to valleys 3, 4, 6, 9, 13 and 16 when `VARIANT_B` is 1.
- R4: On a commit, a set-point strictly below 75, 50, 30, 15 or 6 moves the band past the edge that level belongs to, toward later valleys. A set-point equal to one of these levels does not cross that edge.
- R5: On a commit, the band moves back toward earlier valleys across an edge only when the set-point is strictly above that edge's rising level: 78, 53, 33, 20 or 8. A set-point between an edge's falling level and its rising level keeps the current band.
- R6: A single commit may move the band across several edges at once, directly to the band that the R4 and R5 rules give.
- R7: `valleyIdx` changes only on the clock edge at which `cycleEnd` is 1. It then takes the value for the new band and for the `highLine` value in effect at that edge.
- R8: While `highLine` is 0, it becomes 1 on the clock edge at which `lineAboveHi` has been 1 on `BLANK_CYCLES` consecutive edges. Any edge with `lineAboveHi` at 0 restarts the count, and `lineBelowLo` has no effect.
- R9: While `highLine` is 1, it becomes 0 on the clock edge at which `lineBelowLo` has been 1 on `BLANK_CYCLES` consecutive edges. Any edge with `lineBelowLo` at 0 restarts the count, and `lineAboveHi` has no effect.
- R10: Set-point codes above 100 act as full scale, which gives the first band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setPoint | input | SP_W | Current set-point in percent of full scale |
| lineAboveHi | input | 1 | Line-sense level is above the upper (2.4 V) threshold |
| lineBelowLo | input | 1 | Line-sense level is below the lower (2.3 V) threshold |
| cycleEnd | input | 1 | Switching-cycle boundary strobe; allows a new valley to be applied |
| valleyIdx | output | 5 | Selected valley number, 1 to 16 |
| highLine | output | 1 | Qualified line-range flag, 1 for high line |

## Verification
The set-point is first stepped through one level inside each band, both falling and rising. This shows whether each band maps to the right valley at each line range. It is then placed exactly on each falling and each rising level and one code past it, which tells a strict comparison from an inclusive one and shows the dead zone between the two levels. Large single-commit jumps separate a direct move to the final band from a one-band-per-strobe move. Changes made without the strobe show whether the output is gated by the strobe. Line-flag pulses one clock shorter than the qualification window, each followed by a gap, separate a run-length count from a cumulative one. A long pseudo-random run with set-points near the band edges compares both table variants against the reference on every cycle.

// File: rtl/vs_pkg.sv
package vs_pkg;

  localparam int NUM_STEPS = 5;
  localparam int NUM_BANDS = NUM_STEPS + 1;
  localparam int VALLEY_W  = 5;
  localparam int BAND_W    = $clog2(NUM_BANDS);

  typedef logic [BAND_W-1:0]   band_t;
  typedef logic [VALLEY_W-1:0] valley_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic commit;    // apply a new valley this edge
    logic highLine;  // qualified line range in effect
  } vs_strobe_t;

  // percent level below which edge i is crossed going down
  function automatic int fallLevel(input int i);
    case (i)
      0:       return 75;
      1:       return 50;
      2:       return 30;
      3:       return 15;
      default: return 6;
    endcase
  endfunction

  // percent level above which edge i is crossed going up
  function automatic int riseLevel(input int i);
    case (i)
      0:       return 78;
      1:       return 53;
      2:       return 33;
      3:       return 20;
      default: return 8;
    endcase
  endfunction

  function automatic valley_t valleyFor(input band_t b, input logic hi, input logic varB);
    valley_t lowV;
    valley_t hiV;
    case (b)
      3'd0:    begin lowV = 5'd1;  hiV = 5'd2;  end
      3'd1:    begin lowV = 5'd2;  hiV = 5'd3;  end
      3'd2:    begin lowV = 5'd4;  hiV = 5'd5;  end
      3'd3:    begin lowV = 5'd7;  hiV = 5'd8;  end
      3'd4:    begin lowV = 5'd11; hiV = 5'd12; end
      default: begin lowV = 5'd13; hiV = 5'd15; end
    endcase
    if (!hi)       return lowV;
    else if (varB) return hiV + 5'd1;
    else           return hiV;
  endfunction

endpackage

// File: rtl/vs_ctrl.sv
module vs_ctrl
  import vs_pkg::*;
#(
  parameter int BLANK_CYCLES = 2500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineAboveHi,
  input  logic       lineBelowLo,
  input  logic       cycleEnd,
  output vs_strobe_t strobes
);

  localparam int CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_CYCLES - 1);

  logic             highLine;
  logic [CNT_W-1:0] qualCnt;
  logic             wantFlip;
  logic             reached;

  always_comb begin
    wantFlip = highLine ? lineBelowLo : lineAboveHi;
    reached  = wantFlip && (qualCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highLine <= 1'b0;
      qualCnt  <= '0;
    end else if (reached) begin
      highLine <= ~highLine;
      qualCnt  <= '0;
    end else if (wantFlip) begin
      qualCnt  <= qualCnt + 1'b1;
    end else begin
      qualCnt  <= '0;
    end
  end

  always_comb begin
    strobes.commit   = cycleEnd;
    strobes.highLine = highLine;
  end

  assert_rise_needs_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highLine) |-> $past(lineAboveHi));

  assert_fall_needs_lower_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(highLine) |-> $past(lineBelowLo));

  assert_idle_low_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!highLine && !lineAboveHi) |=> !highLine);

endmodule

// File: rtl/vs_datapath.sv
module vs_datapath
  import vs_pkg::*;
#(
  parameter int SP_W      = 8,
  parameter int VARIANT_B = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SP_W-1:0] setPoint,
  input  vs_strobe_t      strobes,
  output valley_t         valleyIdx
);

  localparam logic VAR_B = (VARIANT_B != 0);

  logic [NUM_STEPS-1:0] belowFall;
  logic [NUM_STEPS-1:0] notAboveRise;
  band_t band;
  band_t fallBand;
  band_t riseBand;
  band_t nextBand;

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_edge
    assign belowFall[i]    = int'(setPoint) <  fallLevel(i);
    assign notAboveRise[i] = int'(setPoint) <= riseLevel(i);
  end

  always_comb begin
    fallBand = '0;
    riseBand = '0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      fallBand = fallBand + band_t'(belowFall[i]);
      riseBand = riseBand + band_t'(notAboveRise[i]);
    end
    if (band < fallBand)      nextBand = fallBand;
    else if (band > riseBand) nextBand = riseBand;
    else                      nextBand = band;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      band      <= '0;
      valleyIdx <= 5'd1;
    end else if (strobes.commit) begin
      band      <= nextBand;
      valleyIdx <= valleyFor(nextBand, strobes.highLine, VAR_B);
    end
  end

  assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(valleyIdx));

  assert_full_scale_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.highLine && int'(setPoint) > 78) |=> valleyIdx == 5'd1);

  assert_full_scale_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && strobes.highLine && int'(setPoint) > 78)
      |=> valleyIdx == (VAR_B ? 5'd3 : 5'd2));

  assert_deep_dim_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.highLine && int'(setPoint) < 6) |=> valleyIdx == 5'd13);

endmodule

// File: rtl/valley_select.sv
module valley_select
  import vs_pkg::*;
#(
  parameter int SP_W         = 8,
  parameter int BLANK_CYCLES = 2500000,
  parameter int VARIANT_B    = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SP_W-1:0] setPoint,
  input  logic            lineAboveHi,
  input  logic            lineBelowLo,
  input  logic            cycleEnd,
  output logic [4:0]      valleyIdx,
  output logic            highLine
);

  vs_strobe_t strobes;

  vs_ctrl #(.BLANK_CYCLES(BLANK_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lineAboveHi (lineAboveHi),
    .lineBelowLo (lineBelowLo),
    .cycleEnd    (cycleEnd),
    .strobes     (strobes)
  );

  vs_datapath #(.SP_W(SP_W), .VARIANT_B(VARIANT_B)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .setPoint  (setPoint),
    .strobes   (strobes),
    .valleyIdx (valleyIdx)
  );

  assign highLine = strobes.highLine;

endmodule

// File: tb/sim_valley_select.sv
`timescale 1ns/1ps
module sim_valley_select;

  localparam int BL = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] setPoint = 8'd100;
  logic       lineAboveHi = 1'b0;
  logic       lineBelowLo = 1'b0;
  logic       cycleEnd = 1'b0;
  logic [4:0] valA, valB;
  logic       hiA, hiB;

  always #5 clk = ~clk;

  valley_select #(.BLANK_CYCLES(BL), .VARIANT_B(0)) u0 (
    .clk(clk), .rstN(rstN), .setPoint(setPoint), .lineAboveHi(lineAboveHi),
    .lineBelowLo(lineBelowLo), .cycleEnd(cycleEnd), .valleyIdx(valA), .highLine(hiA));

  valley_select #(.BLANK_CYCLES(BL), .VARIANT_B(1)) u1 (
    .clk(clk), .rstN(rstN), .setPoint(setPoint), .lineAboveHi(lineAboveHi),
    .lineBelowLo(lineBelowLo), .cycleEnd(cycleEnd), .valleyIdx(valB), .highLine(hiB));

  int tests = 0;
  int fails = 0;
  string curTag = "R1";

  // reference model state
  int mBand = 0;
  int mHigh = 0;
  int mRun  = 0;
  int mValA = 1;
  int mValB = 1;
  int fallAt[5] = '{75, 50, 30, 15, 6};
  int riseAt[5] = '{78, 53, 33, 20, 8};
  int lowTab[6] = '{1, 2, 4, 7, 11, 13};
  int hiTabA[6] = '{2, 3, 5, 8, 12, 15};

  task automatic check(input string tag, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic modelStep();
    int sp;
    int cond;
    if (!rstN) begin
      mBand = 0; mHigh = 0; mRun = 0; mValA = 1; mValB = 1;
      return;
    end
    sp = int'(setPoint);
    if (cycleEnd) begin
      while (mBand < 5 && sp < fallAt[mBand]) mBand++;
      while (mBand > 0 && sp > riseAt[mBand-1]) mBand--;
      mValA = mHigh ? hiTabA[mBand] : lowTab[mBand];
      mValB = mHigh ? hiTabA[mBand] + 1 : lowTab[mBand];
    end
    cond = mHigh ? int'(lineBelowLo) : int'(lineAboveHi);
    if (cond == 0) mRun = 0;
    else begin
      mRun++;
      if (mRun == BL) begin
        mHigh = 1 - mHigh;
        mRun = 0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check({curTag, " valleyA"}, int'(valA), mValA);
    check({curTag, " valleyB"}, int'(valB), mValB);
    check({curTag, " lineA"}, int'(hiA), mHigh);
    check({curTag, " lineB"}, int'(hiB), mHigh);
  endtask

  task automatic commitAt(input int sp);
    setPoint = 8'(sp);
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int spSeq[6] = '{90, 70, 45, 25, 10, 3};
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    curTag = "R1";
    check("R1 reset valley", int'(valA), 1);
    check("R1 reset line", int'(hiA), 0);
    tick();

    // R2 low-line table, falling one band per commit
    curTag = "R2";
    foreach (spSeq[i]) begin
      commitAt(spSeq[i]);
      check("R2 low-line valley", int'(valA), lowTab[i]);
    end
    // R5 rising edges: at level stays, one above moves back
    curTag = "R5";
    commitAt(8);  check("R5 at rise level 8", int'(valA), 13);
    commitAt(9);  check("R5 above rise level 8", int'(valA), 11);
    commitAt(20); check("R5 at rise level 20", int'(valA), 11);
    commitAt(17); check("R5 in dead zone", int'(valA), 11);
    commitAt(21); check("R5 above rise level 20", int'(valA), 7);
    commitAt(79); check("R5 above rise level 78", int'(valA), 1);
    // R4 falling edges: equal does not cross, one below does
    curTag = "R4";
    commitAt(75); check("R4 at fall level 75", int'(valA), 1);
    commitAt(74); check("R4 below fall level 75", int'(valA), 2);
    commitAt(76); check("R4 dead zone 75..78", int'(valA), 2);
    commitAt(6);  check("R4 at fall level 6", int'(valA), 11);
    commitAt(5);  check("R4 below fall level 6", int'(valA), 13);

    // R6 multi-band jumps
    curTag = "R6";
    commitAt(100); check("R6 jump to full", int'(valA), 1);
    commitAt(0);   check("R6 jump to deepest", int'(valA), 13);
    commitAt(40);  check("R6 partial jump", int'(valA), 4);

    // R7 no change without strobe
    curTag = "R7";
    setPoint = 8'd100;
    repeat (4) tick();
    check("R7 held without strobe", int'(valA), 4);
    commitAt(100); check("R7 applied on strobe", int'(valA), 1);

    // R8 qualification with interruption, R9 lower flag ignored at low line
    curTag = "R8";
    lineBelowLo = 1'b1;
    lineAboveHi = 1'b1;
    repeat (BL - 1) tick();
    lineAboveHi = 1'b0;
    tick();
    check("R8 interrupted run", int'(hiA), 0);
    lineBelowLo = 1'b0;
    lineAboveHi = 1'b1;
    repeat (BL - 1) tick();
    check("R8 one short of window", int'(hiA), 0);
    tick();
    check("R8 window complete", int'(hiA), 1);
    check("R7 line change waits for strobe", int'(valA), 1);

    // R3 high-line tables
    curTag = "R3";
    foreach (spSeq[i]) begin
      commitAt(spSeq[i]);
      check("R3 variant A valley", int'(valA), hiTabA[i]);
      check("R3 variant B valley", int'(valB), hiTabA[i] + 1);
    end

    // R9 clear qualification, upper flag ignored while high
    curTag = "R9";
    lineAboveHi = 1'b1;
    lineBelowLo = 1'b1;
    repeat (BL - 1) tick();
    check("R9 one short of window", int'(hiA), 1);
    tick();
    check("R9 window complete", int'(hiA), 0);
    lineAboveHi = 1'b0;
    lineBelowLo = 1'b0;
    commitAt(3); check("R9 back to low table", int'(valA), 13);

    // R10 codes above 100
    curTag = "R10";
    commitAt(200); check("R10 code 200", int'(valA), 1);
    commitAt(255); check("R10 code 255", int'(valA), 1);

    // pseudo-random run near the band edges
    curTag = "R4";
    for (int n = 0; n < 4000; n++) begin
      int pick;
      if (n % 30 == 0) begin
        pick = $urandom_range(0, 2);
        lineAboveHi = (pick == 2);
        lineBelowLo = (pick == 0);
      end
      pick = $urandom_range(0, 9);
      if (pick < 5) setPoint = 8'($urandom_range(0, 110));
      else if (pick < 8) setPoint = 8'(fallAt[$urandom_range(0, 4)] + $urandom_range(0, 2) - 1);
      else setPoint = 8'(riseAt[$urandom_range(0, 4)] + $urandom_range(0, 2) - 1);
      cycleEnd = ($urandom_range(0, 3) == 0);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule